// File: doc/BRIEF.md
# Power State Command Register

This block is a small memory-mapped peripheral with a 256-byte register window on a simple synchronous request/response bus. Software changes the platform power state by writing a single command byte to one control location. The block recognises three command codes, and each accepted command produces a one-cycle request pulse on its own output: system reset, suspend or shutdown. Other logic that owns sequencing, clock gating and wake-up reacts to these pulses. This block only detects and signals the requests.

The register is write-only. Every read returns zero. Only single-byte accesses are legal. A wider access gets an error response and has no side effect. Every access completes one cycle after it is presented, so a bus master never waits more than one cycle.

Top module: `pwr_cmd_regs`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, every output is zero after that edge: the three request outputs, `bus_ready`, `bus_error` and `bus_rdata`. This holds even if an access is presented in the same cycle.
- R2: A single-byte write (`bus_size` = 0) of data 0x00 to byte offset 0x10 sets `req_sys_reset` high for exactly the one cycle after the edge that samples the write.
- R3: A single-byte write of data 0x01 to offset 0x10 sets `req_suspend` high for exactly the one cycle after the edge that samples the write.
- R4: A single-byte write of data 0xFF to offset 0x10 sets `req_power_off` high for exactly the one cycle after the edge that samples the write.
- R5: A single-byte write of any other data value to offset 0x10 raises no request output.
- R6: A write to any offset other than 0x10 raises no request output, whatever its data.
- R7: Every read, at any offset and of any size, returns `bus_rdata` = 0 and raises no request.
- R8: An access with `bus_size` other than 0 (1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes) has `bus_error` high in its response cycle and raises no request, even when its address and data match a command. A single-byte access has `bus_error` low.
- R9: `bus_ready` is high in exactly the cycle after each cycle in which `bus_valid` is high. It is low in every other cycle.
- R10: At most one request output is high in any cycle. No request stays high for two cycles in a row unless a second command was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset inside the window |
| bus_size | input | 2 | log2 of the access size in bytes; 0 = one byte |
| bus_wdata | input | DATA_W (8) | Write data; the low byte carries the command |
| bus_rdata | output | DATA_W (8) | Read data, always zero |
| bus_ready | output | 1 | Access complete, one cycle after `bus_valid` |
| bus_error | output | 1 | Error response for an illegal access size |
| req_sys_reset | output | 1 | One-cycle system reset request |
| req_suspend | output | 1 | One-cycle suspend request |
| req_power_off | output | 1 | One-cycle shutdown request |

## Verification
Every result of this block is due exactly one clock edge after the cycle that presents the access. This covers the request pulse, ready, error and the read data. The bench drives each access on a falling edge and lets one rising edge pass. It then compares all six outputs with its reference model on the next falling edge. After each command the bench inserts idle cycles and checks there as well, which shows that a pulse ends after one cycle and that ready follows valid with no lag or stretch.

// File: rtl/pwrcmd_pkg.sv
package pwrcmd_pkg;

  typedef enum logic [1:0] {
    PCMD_NONE     = 2'd0,
    PCMD_RESET    = 2'd1,
    PCMD_SUSPEND  = 2'd2,
    PCMD_POWEROFF = 2'd3
  } pcmd_e;

  localparam int          NUM_REQ        = 3;
  localparam logic [7:0]  CODE_RESET     = 8'h00;
  localparam logic [7:0]  CODE_SUSPEND   = 8'h01;
  localparam logic [7:0]  CODE_POWEROFF  = 8'hFF;

  function automatic pcmd_e classify(input logic [7:0] code);
    pcmd_e r;
    case (code)
      CODE_RESET:    r = PCMD_RESET;
      CODE_SUSPEND:  r = PCMD_SUSPEND;
      CODE_POWEROFF: r = PCMD_POWEROFF;
      default:       r = PCMD_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwrcmd_decode.sv
module pwrcmd_decode
  import pwrcmd_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          SIZE_W     = 2,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 8'h10
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [7:0]        code,
  output logic              bad_size,
  output pcmd_e             cmd
);
  logic byte_access;
  logic hits_cmd;

  always_comb begin
    byte_access = (size == '0);
    hits_cmd    = valid && write && byte_access && (addr == CMD_OFFSET);
    bad_size    = valid && !byte_access;
    cmd         = hits_cmd ? classify(code) : PCMD_NONE;
  end

  // R8: an oversized access never forms a command
  always_comb begin
    a_r8_size_blocks_cmd: assert (!(bad_size && cmd != PCMD_NONE));
  end
endmodule

// File: rtl/pwrcmd_pulse.sv
module pwrcmd_pulse
  import pwrcmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pcmd_e              cmd,
  output logic [NUM_REQ-1:0] req
);
  logic [NUM_REQ-1:0] req_q;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) req_q[g] <= 1'b0;
      else     req_q[g] <= (cmd == pcmd_e'(g + 1));
    end

    // R10: a request lasts one cycle unless the same command repeats
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (req_q[g] && cmd != pcmd_e'(g + 1)) |=> !req_q[g]);
  end

  assign req = req_q;

  // R10: request outputs are mutually exclusive
  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_q));
endmodule

// File: rtl/pwrcmd_resp.sv
module pwrcmd_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              bad_size,
  output logic              ready,
  output logic              error,
  output logic [DATA_W-1:0] rdata
);
  logic              ready_q;
  logic              error_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      error_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= valid;
      error_q <= bad_size;
      rdata_q <= '0;
    end
  end

  assign ready = ready_q;
  assign error = error_q;
  assign rdata = rdata_q;

  // R9: completion one cycle after the request, never otherwise
  a_r9_ready_follows: assert property (@(posedge clk) disable iff (rst)
    valid |=> ready_q);
  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !ready_q);
  // R8: an error only accompanies a completion
  a_r8_error_with_ready: assert property (@(posedge clk) disable iff (rst)
    error_q |-> ready_q);
endmodule

// File: rtl/pwr_cmd_regs.sv
module pwr_cmd_regs
  import pwrcmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 2,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_error,
  output logic              req_sys_reset,
  output logic              req_suspend,
  output logic              req_power_off
);
  pcmd_e              cmd;
  logic               bad_size;
  logic [NUM_REQ-1:0] req;

  pwrcmd_decode #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .CMD_OFFSET(CMD_OFFSET)
  ) i_decode (
    .valid   (bus_valid),
    .write   (bus_write),
    .addr    (bus_addr),
    .size    (bus_size),
    .code    (bus_wdata[7:0]),
    .bad_size(bad_size),
    .cmd     (cmd)
  );

  pwrcmd_pulse i_pulse (
    .clk(clk),
    .rst(rst),
    .cmd(cmd),
    .req(req)
  );

  pwrcmd_resp #(.DATA_W(DATA_W)) i_resp (
    .clk     (clk),
    .rst     (rst),
    .valid   (bus_valid),
    .bad_size(bad_size),
    .ready   (bus_ready),
    .error   (bus_error),
    .rdata   (bus_rdata)
  );

  assign req_sys_reset = req[0];
  assign req_suspend   = req[1];
  assign req_power_off = req[2];

  // R6: writes outside the command offset raise nothing
  a_r6_offset_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr != CMD_OFFSET) |=> (req == '0));
  // R7: reads raise nothing
  a_r7_read_quiet: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> (req == '0));
  // R8: an error response never comes with a request
  a_r8_error_no_req: assert property (@(posedge clk) disable iff (rst)
    bus_error |-> (req == '0));
endmodule

// File: tb/test_pwr_cmd_regs.sv
`timescale 1ns/1ps
module test_pwr_cmd_regs;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_valid, bus_write;
  logic [7:0] bus_addr;
  logic [1:0] bus_size;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       bus_ready, bus_error;
  logic       req_sys_reset, req_suspend, req_power_off;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pwr_cmd_regs i_pwr_cmd_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_error(bus_error),
    .req_sys_reset(req_sys_reset), .req_suspend(req_suspend),
    .req_power_off(req_power_off)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle at a falling edge; check outputs at the next falling edge.
  task automatic step(input string tag, input bit r, input bit v, input bit w,
                      input int a, input int sz, input int d);
    int er, es, ep, erdy, eerr;
    rst = r; bus_valid = v; bus_write = w;
    bus_addr = 8'(a); bus_size = 2'(sz); bus_wdata = 8'(d);
    erdy = (!r && v) ? 1 : 0;
    eerr = (!r && v && sz != 0) ? 1 : 0;
    er = 0; es = 0; ep = 0;
    if (!r && v && w && sz == 0 && a == 16) begin
      if (d == 0)   er = 1;
      if (d == 1)   es = 1;
      if (d == 255) ep = 1;
    end
    @(negedge clk);
    cmp(tag, "req_sys_reset", int'(req_sys_reset), er);
    cmp(tag, "req_suspend",   int'(req_suspend),   es);
    cmp(tag, "req_power_off", int'(req_power_off), ep);
    cmp(tag, "bus_ready",     int'(bus_ready),     erdy);
    cmp(tag, "bus_error",     int'(bus_error),     eerr);
    cmp(tag, "bus_rdata",     int'(bus_rdata),     0);
    cmp("R10", "onehot", ($countones({req_sys_reset, req_suspend, req_power_off}) <= 1) ? 1 : 0, 1);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 1'b0, 0, 0, 0);
  endtask

  initial begin
    rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_size = 0; bus_wdata = 0;
    @(negedge clk);
    // R1: reset state, also with a matching command presented
    step("R1", 1'b1, 1'b0, 1'b0, 0, 0, 0);
    step("R1", 1'b1, 1'b1, 1'b1, 16, 0, 0);
    step("R1", 1'b1, 1'b1, 1'b1, 16, 1, 255);
    idle("R9");
    // R2, R3, R4: each command then idle (pulse ends, R10)
    step("R2", 1'b0, 1'b1, 1'b1, 16, 0, 8'h00); idle("R10");
    step("R3", 1'b0, 1'b1, 1'b1, 16, 0, 8'h01); idle("R10");
    step("R4", 1'b0, 1'b1, 1'b1, 16, 0, 8'hFF); idle("R10");
    // back-to-back different commands
    step("R2", 1'b0, 1'b1, 1'b1, 16, 0, 8'h00);
    step("R4", 1'b0, 1'b1, 1'b1, 16, 0, 8'hFF);
    step("R3", 1'b0, 1'b1, 1'b1, 16, 0, 8'h01);
    step("R3", 1'b0, 1'b1, 1'b1, 16, 0, 8'h01);
    idle("R10"); idle("R9");
    // R5: other codes at the command offset
    for (int d = 2; d < 255; d += 7) step("R5", 1'b0, 1'b1, 1'b1, 16, 0, d);
    step("R5", 1'b0, 1'b1, 1'b1, 16, 0, 8'hFE);
    step("R5", 1'b0, 1'b1, 1'b1, 16, 0, 8'h80);
    // R6: command codes at other offsets
    for (int a = 0; a < 256; a += 5) begin
      if (a != 16) begin
        step("R6", 1'b0, 1'b1, 1'b1, a, 0, 0);
        step("R6", 1'b0, 1'b1, 1'b1, a, 0, 255);
      end
    end
    step("R6", 1'b0, 1'b1, 1'b1, 17, 0, 1);
    step("R6", 1'b0, 1'b1, 1'b1, 15, 0, 0);
    // R7: reads everywhere, all sizes
    for (int a = 0; a < 256; a += 16) begin
      for (int s = 0; s < 4; s++) step("R7", 1'b0, 1'b1, 1'b0, a, s, 0);
    end
    // R8: wide accesses that would otherwise be commands
    for (int s = 1; s < 4; s++) begin
      step("R8", 1'b0, 1'b1, 1'b1, 16, s, 8'h00);
      step("R8", 1'b0, 1'b1, 1'b1, 16, s, 8'h01);
      step("R8", 1'b0, 1'b1, 1'b1, 16, s, 8'hFF);
      idle("R9");
    end
    // R9: idle gap then a valid burst
    idle("R9"); idle("R9");
    step("R9", 1'b0, 1'b1, 1'b0, 3, 0, 0);
    step("R9", 1'b0, 1'b1, 1'b1, 16, 0, 0);
    idle("R9");
    // R1: reset in the middle of traffic clears a pending command
    step("R1", 1'b1, 1'b1, 1'b1, 16, 0, 8'hFF);
    step("R2", 1'b0, 1'b1, 1'b1, 16, 0, 8'h00);
    idle("R10");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule